// File: doc/BRIEF.md
# Ordered Multi-Rail Voltage Sequencer

The sequencer moves three supply rails (memory, digital logic and core) to new voltage levels around a clock frequency change. The controller issues one command per change. The command carries a phase, a reason code and the target levels. In the raise phase, which runs before the clock switch, rails go up in the order memory, digital, core. In the lower phase, which runs after the switch, rails go down in the reverse order. Mirroring the order keeps the memory rail at or above the digital rail throughout.

The digital target is not supplied directly. The block derives it from the shared cache's own digital voltage and from a PLL term. The PLL term depends on whether the cache is clocked from the PLL and on the size of the PLL multiplier. Each rail change is a request/acknowledge transaction with an external regulator port. The port may answer with an error, or may not answer at all. Either case ends the phase with an error status. The block records a new level for a rail only after that rail's change has been acknowledged without error.

Top module: `vrail_seq`

## Requirements
- R1: With `phase`=0 (raise), rails are visited in the order memory (rail code 0), digital (1), core (2). A rail is requested only if its target is strictly greater than its current level.
- R2: With `phase`=1 (lower), rails are visited in the order core (2), digital (1), memory (0). A rail is requested only if its target is strictly below its current level.
- R3: With `reason`=1 (hotplug), no request is ever issued for the core rail in either phase.
- R4: An acknowledge with `ack_err`=1 ends the phase at once. No further rail is requested, and `err` reads 1 when `done` pulses.
- R5: The digital target is the maximum of `cache_dig` and a PLL term. The PLL term is PLL_V_NONE when `cache_on_pll`=0. It is PLL_V_NOM when `pll_mult` > LOW_MULT_MAX. Otherwise it is PLL_V_LOW.
- R6: A rail's current level (`cur_*`) changes only on an error-free acknowledge, and then takes the requested level. Every request carries the rail's fixed maximum on `req_max`.
- R7: With `phase`=1 and `reason` 2 (power collapse) or 3 (wait-for-interrupt), the command completes with `done` and no error, and issues no request.
- R8: A request not acknowledged within TIMEOUT cycles is withdrawn. It ends the phase with `err`=1 and leaves the rail level unchanged.
- R9: After reset, the current levels equal INIT_MEM, INIT_DIG and INIT_CORE, and `busy`, `done`, `err` and `req_valid` are all 0.
- R10: A `start` pulse while a command is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, accepted when idle |
| phase | input | 1 | 0 raise, 1 lower |
| reason | input | 2 | 0 frequency scaling, 1 hotplug, 2 power collapse, 3 wait-for-interrupt |
| tgt_mem | input | VW | Memory rail target |
| tgt_core | input | VW | Core rail target |
| cache_dig | input | VW | Digital voltage of the cache operating point |
| cache_on_pll | input | 1 | Cache clocked from the PLL |
| pll_mult | input | MW | Cache PLL multiplier |
| req_valid | output | 1 | Regulator request pending |
| req_rail | output | 2 | Rail code of the request |
| req_level | output | VW | Requested level |
| req_max | output | VW | Rail maximum |
| ack | input | 1 | Regulator acknowledge |
| ack_err | input | 1 | Acknowledge carries an error |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last command failed, held until the next start |
| cur_mem | output | VW | Current memory level |
| cur_dig | output | VW | Current digital level |
| cur_core | output | VW | Current core level |

## Verification
The bench builds the block with TIMEOUT=6. This lets a silent regulator reach the withdrawal path within a few cycles. LOW_MULT_MAX is 40, so multipliers of 40 and 41 fall on either side of the low/nominal boundary of the PLL term. The three rail maxima are distinct (200, 180, 160), so a request carrying the wrong rail's maximum is visible. The initial levels (100, 80, 90) lie between the test targets, so each test can push every rail either up or down from reset.

// File: rtl/vrail_pkg.sv
package vrail_pkg;
  localparam int NRAIL = 3;

  typedef enum logic [1:0] {
    RAIL_MEM  = 2'd0,
    RAIL_DIG  = 2'd1,
    RAIL_CORE = 2'd2
  } rail_e;

  localparam logic [1:0] WHY_HOTPLUG  = 2'd1;
  localparam logic [1:0] WHY_COLLAPSE = 2'd2;
  localparam logic [1:0] WHY_IDLEWAIT = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CHK  = 2'd1,
    ST_REQ  = 2'd2,
    ST_FIN  = 2'd3
  } st_e;
endpackage

// File: rtl/vrail_dig_target.sv
module vrail_dig_target #(
  parameter int VW = 8,
  parameter int MW = 8,
  parameter int LOW_MULT_MAX = 40,
  parameter int PLL_V_NONE = 10,
  parameter int PLL_V_LOW = 30,
  parameter int PLL_V_NOM = 60
) (
  input  logic [VW-1:0] cache_dig,
  input  logic          on_pll,
  input  logic [MW-1:0] mult,
  output logic [VW-1:0] dig_tgt
);
  localparam logic [VW-1:0] V_NONE = VW'(PLL_V_NONE);
  localparam logic [VW-1:0] V_LOW  = VW'(PLL_V_LOW);
  localparam logic [VW-1:0] V_NOM  = VW'(PLL_V_NOM);
  localparam logic [MW-1:0] M_LIM  = MW'(LOW_MULT_MAX);

  logic [VW-1:0] pll_v;

  always_comb begin
    if (!on_pll)          pll_v = V_NONE;
    else if (mult > M_LIM) pll_v = V_NOM;
    else                  pll_v = V_LOW;
    dig_tgt = (cache_dig > pll_v) ? cache_dig : pll_v;
  end
endmodule

// File: rtl/vrail_order.sv
module vrail_order
  import vrail_pkg::*;
(
  input  logic       lower,
  input  logic [1:0] step,
  output rail_e      rail
);
  always_comb begin
    unique case (lower ? (2'd2 - step) : step)
      2'd0:    rail = RAIL_MEM;
      2'd1:    rail = RAIL_DIG;
      default: rail = RAIL_CORE;
    endcase
  end
endmodule

// File: rtl/vrail_timer.sv
module vrail_timer #(
  parameter int TIMEOUT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = run ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/vrail_seq.sv
module vrail_seq
  import vrail_pkg::*;
#(
  parameter int VW = 8,
  parameter int MW = 8,
  parameter int LOW_MULT_MAX = 40,
  parameter int PLL_V_NONE = 10,
  parameter int PLL_V_LOW = 30,
  parameter int PLL_V_NOM = 60,
  parameter int MAX_MEM = 200,
  parameter int MAX_DIG = 180,
  parameter int MAX_CORE = 160,
  parameter int INIT_MEM = 100,
  parameter int INIT_DIG = 80,
  parameter int INIT_CORE = 90,
  parameter int TIMEOUT = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          phase,
  input  logic [1:0]    reason,
  input  logic [VW-1:0] tgt_mem,
  input  logic [VW-1:0] tgt_core,
  input  logic [VW-1:0] cache_dig,
  input  logic          cache_on_pll,
  input  logic [MW-1:0] pll_mult,
  output logic          req_valid,
  output logic [1:0]    req_rail,
  output logic [VW-1:0] req_level,
  output logic [VW-1:0] req_max,
  input  logic          ack,
  input  logic          ack_err,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [VW-1:0] cur_mem,
  output logic [VW-1:0] cur_dig,
  output logic [VW-1:0] cur_core
);
  localparam logic [1:0] LAST_STEP = 2'(NRAIL - 1);

  st_e           st_q, st_d;
  logic [1:0]    step_q, step_d;
  logic          phase_q;
  logic [1:0]    why_q;
  logic          err_q, err_d;
  logic [VW-1:0] tgt_q [NRAIL];
  logic [VW-1:0] cur_q [NRAIL];
  logic [VW-1:0] dig_tgt;
  logic          ld, upd, expired, need, skip_all, core_lock;
  rail_e         rail;
  logic [1:0]    ri;

  vrail_dig_target #(
    .VW(VW), .MW(MW), .LOW_MULT_MAX(LOW_MULT_MAX),
    .PLL_V_NONE(PLL_V_NONE), .PLL_V_LOW(PLL_V_LOW), .PLL_V_NOM(PLL_V_NOM)
  ) u_dig (
    .cache_dig(cache_dig), .on_pll(cache_on_pll), .mult(pll_mult), .dig_tgt(dig_tgt)
  );

  vrail_order u_order (.lower(phase_q), .step(step_q), .rail(rail));

  vrail_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(st_q == ST_REQ), .expired(expired)
  );

  assign ri        = rail;
  assign ld        = start && (st_q == ST_IDLE);
  assign skip_all  = phase && ((reason == WHY_COLLAPSE) || (reason == WHY_IDLEWAIT));
  assign core_lock = (why_q == WHY_HOTPLUG) && (rail == RAIL_CORE);
  assign need      = !core_lock &&
                     (phase_q ? (tgt_q[ri] < cur_q[ri]) : (tgt_q[ri] > cur_q[ri]));
  assign upd       = (st_q == ST_REQ) && ack && !ack_err;

  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    err_d  = err_q;
    unique case (st_q)
      ST_IDLE: if (ld) begin
        err_d  = 1'b0;
        step_d = '0;
        st_d   = skip_all ? ST_FIN : ST_CHK;
      end
      ST_CHK: begin
        if (need)                    st_d = ST_REQ;
        else if (step_q == LAST_STEP) st_d = ST_FIN;
        else                         step_d = step_q + 1'b1;
      end
      ST_REQ: begin
        if (ack && ack_err) begin
          err_d = 1'b1;
          st_d  = ST_FIN;
        end else if (ack) begin
          if (step_q == LAST_STEP) st_d = ST_FIN;
          else begin
            st_d   = ST_CHK;
            step_d = step_q + 1'b1;
          end
        end else if (expired) begin
          err_d = 1'b1;
          st_d  = ST_FIN;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      why_q   <= '0;
      tgt_q   <= '{default: '0};
    end else if (ld) begin
      phase_q           <= phase;
      why_q             <= reason;
      tgt_q[RAIL_MEM]   <= tgt_mem;
      tgt_q[RAIL_DIG]   <= dig_tgt;
      tgt_q[RAIL_CORE]  <= tgt_core;
    end
  end

  for (genvar r = 0; r < NRAIL; r++) begin : g_rail
    localparam logic [VW-1:0] INITV = (r == 0) ? VW'(INIT_MEM) :
                                      (r == 1) ? VW'(INIT_DIG) : VW'(INIT_CORE);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cur_q[r] <= INITV;
      else if (upd && (ri == 2'(r)))       cur_q[r] <= tgt_q[r];
    end
  end

  always_comb begin
    unique case (rail)
      RAIL_MEM: req_max = VW'(MAX_MEM);
      RAIL_DIG: req_max = VW'(MAX_DIG);
      default:  req_max = VW'(MAX_CORE);
    endcase
  end

  assign req_valid = (st_q == ST_REQ);
  assign req_rail  = ri;
  assign req_level = tgt_q[ri];
  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_FIN);
  assign err       = err_q;
  assign cur_mem   = cur_q[RAIL_MEM];
  assign cur_dig   = cur_q[RAIL_DIG];
  assign cur_core  = cur_q[RAIL_CORE];
endmodule

// File: rtl/vrail_seq_chk.sv
module vrail_seq_chk #(
  parameter int VW = 8,
  parameter int TIMEOUT = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [1:0]    req_rail,
  input logic [VW-1:0] req_level,
  input logic          ack,
  input logic          ack_err,
  input logic          done,
  input logic [VW-1:0] cur_mem,
  input logic [VW-1:0] cur_dig,
  input logic [VW-1:0] cur_core,
  input logic          phase_q,
  input logic [1:0]    why_q
);
  localparam int CW = $clog2(TIMEOUT + 2);

  logic [VW-1:0] cur_sel;
  logic [CW-1:0] wait_q;

  always_comb begin
    case (req_rail)
      2'd0:    cur_sel = cur_mem;
      2'd1:    cur_sel = cur_dig;
      default: cur_sel = cur_core;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wait_q <= '0;
    else if (req_valid && !ack) wait_q <= wait_q + 1'b1;
    else                        wait_q <= '0;
  end

  assert_raise_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !phase_q |-> req_level > cur_sel);

  assert_lower_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && phase_q |-> req_level < cur_sel);

  assert_core_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (why_q == 2'd1) |-> req_rail != 2'd2);

  assert_err_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && ack && ack_err |=> !req_valid && done);

  assert_level_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && ack && !ack_err) |=> $stable({cur_mem, cur_dig, cur_core}));

  assert_no_lower_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !(phase_q && why_q[1]));

  assert_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> wait_q < CW'(TIMEOUT));

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !ack && (wait_q < CW'(TIMEOUT - 1)) |=> req_valid && $stable(req_rail));
endmodule

bind vrail_seq vrail_seq_chk #(.VW(VW), .TIMEOUT(TIMEOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rail(req_rail),
  .req_level(req_level), .ack(ack), .ack_err(ack_err), .done(done),
  .cur_mem(cur_mem), .cur_dig(cur_dig), .cur_core(cur_core),
  .phase_q(phase_q), .why_q(why_q)
);

// File: tb/vrail_seq_tb.sv
module vrail_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, phase = 1'b0, cache_on_pll = 1'b0;
  logic [1:0] reason = 2'd0;
  logic [7:0] tgt_mem = '0, tgt_core = '0, cache_dig = '0, pll_mult = '0;
  logic       req_valid, busy, done, err;
  logic [1:0] req_rail;
  logic [7:0] req_level, req_max, cur_mem, cur_dig, cur_core;
  logic       ack = 1'b0, ack_err = 1'b0;

  int n_chk = 0, n_bad = 0;
  int n_log = 0;
  int log_rail [8], log_lvl [8], log_max [8];
  int rsp_delay = 1;
  int err_rail = 3;
  bit silent = 0;
  bit fin = 0;

  always #10 clk = ~clk;

  vrail_seq #(
    .VW(8), .MW(8), .LOW_MULT_MAX(40), .PLL_V_NONE(10), .PLL_V_LOW(30),
    .PLL_V_NOM(60), .MAX_MEM(200), .MAX_DIG(180), .MAX_CORE(160),
    .INIT_MEM(100), .INIT_DIG(80), .INIT_CORE(90), .TIMEOUT(6)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .phase(phase), .reason(reason),
    .tgt_mem(tgt_mem), .tgt_core(tgt_core), .cache_dig(cache_dig),
    .cache_on_pll(cache_on_pll), .pll_mult(pll_mult), .req_valid(req_valid),
    .req_rail(req_rail), .req_level(req_level), .req_max(req_max), .ack(ack),
    .ack_err(ack_err), .busy(busy), .done(done), .err(err), .cur_mem(cur_mem),
    .cur_dig(cur_dig), .cur_core(cur_core)
  );

  // regulator model
  initial begin
    int w;
    w = 0;
    forever begin
      @(negedge clk);
      if (ack) begin
        ack = 1'b0; ack_err = 1'b0;
      end else if (req_valid && !silent) begin
        w++;
        if (w >= rsp_delay) begin
          ack = 1'b1;
          ack_err = (int'(req_rail) == err_rail);
          if (n_log < 8) begin
            log_rail[n_log] = req_rail; log_lvl[n_log] = req_level; log_max[n_log] = req_max;
          end
          n_log++;
          w = 0;
        end
      end else w = 0;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(bit ph, int why, int mem, int cd, bit onp, int mult, int core);
    @(negedge clk);
    n_log = 0;
    phase = ph; reason = 2'(why); tgt_mem = 8'(mem); cache_dig = 8'(cd);
    cache_on_pll = onp; pll_mult = 8'(mult); tgt_core = 8'(core);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(string tag);
    for (int i = 0; i < 200; i++) begin
      if (done) return;
      @(negedge clk);
    end
    check({tag, " done timeout"}, 0, 1);
  endtask

  task automatic check_levels(string tag, int m, int d, int c);
    check({tag, " cur_mem"}, cur_mem, m);
    check({tag, " cur_dig"}, cur_dig, d);
    check({tag, " cur_core"}, cur_core, c);
  endtask

  task automatic check_log(string tag, int idx, int rail, int lvl);
    int mx;
    mx = (rail == 0) ? 200 : (rail == 1) ? 180 : 160;
    check({tag, " log rail"}, log_rail[idx], rail);
    check({tag, " log level"}, log_lvl[idx], lvl);
    check({tag, " log max R6"}, log_max[idx], mx);
  endtask

  task automatic t_reset();
    check("R9 cur_mem", cur_mem, 100);
    check("R9 cur_dig", cur_dig, 80);
    check("R9 cur_core", cur_core, 90);
    check("R9 busy", busy, 0);
    check("R9 done", done, 0);
    check("R9 err", err, 0);
    check("R9 req_valid", req_valid, 0);
  endtask

  task automatic t_raise_all();
    issue(0, 0, 120, 90, 1, 50, 110);
    wait_done("R1 raise_all");
    check("R1 count", n_log, 3);
    check_log("R1 step0", 0, 0, 120);
    check_log("R1 step1", 1, 1, 90);
    check_log("R1 step2", 2, 2, 110);
    check("R1 err", err, 0);
    check_levels("R6 raise_all", 120, 90, 110);
  endtask

  task automatic t_raise_partial();
    issue(0, 0, 110, 20, 1, 50, 130);
    wait_done("R1 partial");
    check("R1 partial count", n_log, 1);
    check_log("R1 partial", 0, 2, 130);
    check_levels("R1 partial", 120, 90, 130);
  endtask

  task automatic t_dig_formula();
    issue(1, 0, 120, 20, 0, 50, 130);   // no PLL: max(20,10)=20
    wait_done("R5 none");
    check("R5 none count", n_log, 1);
    check_log("R5 none", 0, 1, 20);
    issue(0, 0, 120, 5, 1, 40, 130);    // mult at threshold: low 30
    wait_done("R5 low");
    check("R5 low count", n_log, 1);
    check_log("R5 low", 0, 1, 30);
    issue(0, 0, 120, 5, 1, 41, 130);    // above threshold: nominal 60
    wait_done("R5 nom");
    check("R5 nom count", n_log, 1);
    check_log("R5 nom", 0, 1, 60);
    check_levels("R5", 120, 60, 130);
  endtask

  task automatic t_lower_order();
    issue(1, 0, 90, 40, 0, 0, 70);
    wait_done("R2 lower");
    check("R2 count", n_log, 3);
    check_log("R2 step0", 0, 2, 70);
    check_log("R2 step1", 1, 1, 40);
    check_log("R2 step2", 2, 0, 90);
    check_levels("R2", 90, 40, 70);
  endtask

  task automatic t_hotplug();
    issue(0, 1, 100, 50, 0, 0, 150);
    wait_done("R3 raise");
    check("R3 raise count", n_log, 2);
    check_log("R3 raise0", 0, 0, 100);
    check_log("R3 raise1", 1, 1, 50);
    issue(1, 1, 100, 50, 0, 0, 10);
    wait_done("R3 lower");
    check("R3 lower count", n_log, 0);
    check("R3 lower err", err, 0);
    check_levels("R3", 100, 50, 70);
  endtask

  task automatic t_skip_lower();
    issue(1, 2, 10, 5, 0, 0, 10);
    wait_done("R7 collapse");
    check("R7 collapse count", n_log, 0);
    check("R7 collapse err", err, 0);
    issue(1, 3, 10, 5, 0, 0, 10);
    wait_done("R7 idlewait");
    check("R7 idlewait count", n_log, 0);
    check("R7 idlewait err", err, 0);
    check_levels("R7", 100, 50, 70);
  endtask

  task automatic t_error();
    err_rail = 1;
    issue(0, 0, 110, 70, 0, 0, 80);
    wait_done("R4 error");
    err_rail = 3;
    check("R4 count", n_log, 2);
    check_log("R4 first", 0, 0, 110);
    check("R4 err", err, 1);
    check_levels("R4", 110, 50, 70);
  endtask

  task automatic t_timeout();
    int cyc;
    silent = 1;
    issue(0, 0, 130, 50, 0, 0, 70);
    cyc = 0;
    while (!done && cyc < 50) begin @(negedge clk); cyc++; end
    silent = 0;
    check("R8 finished", done, 1);
    check("R8 bounded", int'(cyc <= 10), 1);
    check("R8 err", err, 1);
    check_levels("R8", 110, 50, 70);
  endtask

  task automatic t_busy_ignore();
    rsp_delay = 3;
    issue(0, 0, 120, 50, 0, 0, 70);
    @(negedge clk);
    tgt_mem = 8'd200; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R10 busy");
    rsp_delay = 1;
    check("R10 count", n_log, 1);
    check_log("R10", 0, 0, 120);
    check("R10 err cleared", err, 0);
    @(negedge clk); @(negedge clk);
    check("R10 idle after", busy, 0);
    check_levels("R10", 120, 50, 70);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_raise_all();
    t_raise_partial();
    t_dig_formula();
    t_lower_order();
    t_hotplug();
    t_skip_lower();
    t_error();
    t_timeout();
    t_busy_ignore();
    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule